// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the lowest address bits for a four-beat burst on a synchronous memory. When an external address is captured, by either of two active-low address strobes qualified by an acceptance input from the chip-enable decode, the block stores the two low bits of that address as the burst start and resets its beat index. Each later rising edge with the active-low advance input asserted moves the burst on by one beat; with neither a load nor an advance the position holds.

The order in which the four positions are visited is picked by a static strap: low selects a linear order (start plus beat index, modulo four), high selects an interleaved order (start XOR beat index). After the fourth beat a further advance returns to the start position and raises a wrap flag for exactly one cycle. The upper address bits, the chip-enable decode and the array itself live outside this block.

Top module: `burst_seq`

## Requirements
- R1: While reset is applied, and in the cycles after it until the first load, `burst_addr` is 0 and `wrap_pulse` is 0.
- R2: A rising edge with `strobe_p_n` low and `accept` high loads `addr_lo`; from that edge `burst_addr` equals the loaded value.
- R3: A rising edge with `strobe_c_n` low and `accept` high loads `addr_lo` in the same way; with both strobes low the single load takes place.
- R4: A strobe at a rising edge where `accept` is low is ignored: with `adv_n` high, `burst_addr` keeps its value.
- R5: With `order_sel` low (linear), beat k of a burst (k = 0..3) presents (start + k) mod 4; a start of 2 gives 2, 3, 0, 1.
- R6: With `order_sel` high (interleaved), beat k presents start XOR k; a start of 1 gives 1, 0, 3, 2 and a start of 3 gives 3, 2, 1, 0.
- R7: A load and an advance at the same edge perform the load only, and the beat index restarts at 0.
- R8: An advance taken from beat 3 returns `burst_addr` to the start value and sets `wrap_pulse` high for that one cycle only.
- R9: A rising edge with no accepted strobe and `adv_n` high leaves `burst_addr` unchanged and `wrap_pulse` low.
- R10: `rst_n` clears the block at once when pulled low; its release takes effect on the second rising edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| accept | input | 1 | High when the chip-enable decode accepts the current strobe |
| adv_n | input | 1 | Advance, active low: step to the next beat |
| addr_lo | input | 2 | Low address bits loaded as the burst start |
| order_sel | input | 1 | Static strap: 0 linear order, 1 interleaved order |
| burst_addr | output | 2 | Current low address bits of the burst |
| wrap_pulse | output | 1 | One-cycle flag on the advance that returns to the start |

## Verification
Every result of this block is registered once: inputs applied before a rising edge show on `burst_addr` and `wrap_pulse` just after that same edge, since the order mapping after the registers is combinational. The driver sets inputs on the falling edge and queues the expected address and wrap value for the next rising edge; the monitor samples a quarter period after each rising edge and pops one item, so each check lands in the cycle the result is due. After reset release the bench idles three cycles, longer than the two-edge synchronizer delay, before queuing anything, and the strap changes only between bursts.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Burst ordering selected by the static strap.
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_ctl.sv
module burst_ctl #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] start_q,
  output logic [W-1:0] beat_q,
  output logic         wrap_q
);
  localparam logic [W-1:0] LAST_BEAT = {W{1'b1}};

  logic [W-1:0] start_d;
  logic [W-1:0] beat_d;
  logic         wrap_d;
  logic         start_en;
  logic         beat_en;

  // Next-state: load wins over step; otherwise hold.
  always_comb begin
    start_en = load;
    beat_en  = load | step;
    start_d  = start_i;
    beat_d   = beat_q;
    wrap_d   = 1'b0;
    if (load) begin
      beat_d = '0;
    end else if (step) begin
      beat_d = beat_q + W'(1);
      wrap_d = (beat_q == LAST_BEAT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      wrap_q  <= 1'b0;
    end else begin
      if (start_en) start_q <= start_d;
      if (beat_en)  beat_q  <= beat_d;
      wrap_q <= wrap_d;
    end
  end
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] beat_i,
  input  order_e       order_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] lin_addr;
  logic [W-1:0] ilv_addr;

  // Linear: modular sum of start and beat index.
  assign lin_addr = start_i + beat_i;

  // Interleaved: each bit flips where the beat index has a one.
  for (genvar b = 0; b < W; b++) begin : g_ilv
    assign ilv_addr[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    case (order_i)
      ORD_INTERLEAVE: addr_o = ilv_addr;
      default:        addr_o = lin_addr;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int W          = 2,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_p_n,
  input  logic         strobe_c_n,
  input  logic         accept,
  input  logic         adv_n,
  input  logic [W-1:0] addr_lo,
  input  logic         order_sel,
  output logic [W-1:0] burst_addr,
  output logic         wrap_pulse
);
  logic         rst_core_n;
  logic         load;
  logic         step;
  logic [W-1:0] start_q;
  logic [W-1:0] beat_q;
  order_e       order;

  assign load  = accept & (~strobe_p_n | ~strobe_c_n);
  assign step  = ~adv_n;
  assign order = order_e'(order_sel);

  rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  burst_ctl #(.W(W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (load),
    .step    (step),
    .start_i (addr_lo),
    .start_q (start_q),
    .beat_q  (beat_q),
    .wrap_q  (wrap_pulse)
  );

  burst_order #(.W(W)) u_ord (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (order),
    .addr_o  (burst_addr)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         strobe_p_n,
  input logic         strobe_c_n,
  input logic         accept,
  input logic         adv_n,
  input logic [W-1:0] addr_lo,
  input logic         order_sel,
  input logic [W-1:0] burst_addr,
  input logic         wrap_pulse
);
  logic take;
  assign take = accept && (!strobe_p_n || !strobe_c_n);

  // R2 R3 R7: a load presents the start value, even with advance asserted.
  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> burst_addr == $past(addr_lo));

  // R4 R9: no load and no advance keeps the address (strap assumed static).
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && adv_n) |=> ((order_sel != $past(order_sel)) || ($stable(burst_addr) && !wrap_pulse)));

  // R5: linear order steps by one.
  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !adv_n && !order_sel) |=> (order_sel || burst_addr == $past(burst_addr) + W'(1)));

  // R8: the wrap flag lasts a single cycle.
  assert_wrap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

  // R8: the wrap flag only follows an advance without load.
  assert_wrap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_pulse) |-> $past(!adv_n && !take));
endmodule

bind burst_seq burst_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .strobe_p_n (strobe_p_n),
  .strobe_c_n (strobe_c_n),
  .accept     (accept),
  .adv_n      (adv_n),
  .addr_lo    (addr_lo),
  .order_sel  (order_sel),
  .burst_addr (burst_addr),
  .wrap_pulse (wrap_pulse)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
  logic       clk;
  logic       rst_n;
  logic       strobe_p_n;
  logic       strobe_c_n;
  logic       accept;
  logic       adv_n;
  logic [1:0] addr_lo;
  logic       order_sel;
  logic [1:0] burst_addr;
  logic       wrap_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int    q_addr[$];
  int    q_wrap[$];
  string q_tag[$];

  // Bench model state
  logic [1:0] m_start = 2'd0;
  logic [1:0] m_beat  = 2'd0;

  burst_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .accept     (accept),
    .adv_n      (adv_n),
    .addr_lo    (addr_lo),
    .order_sel  (order_sel),
    .burst_addr (burst_addr),
    .wrap_pulse (wrap_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic int expect_addr();
    if (order_sel) return int'(m_start ^ m_beat);
    return int'(2'(m_start + m_beat));
  endfunction

  task automatic check(input string tag, input int act_a, input int exp_a,
                       input int act_w, input int exp_w);
    total++;
    if (act_a != exp_a || act_w != exp_w) begin
      bad++;
      $display("FAIL %s: addr=%0d wrap=%0d expected addr=%0d wrap=%0d",
               tag, act_a, act_w, exp_a, exp_w);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the result due after the next edge.
  task automatic step(input logic p_n, input logic c_n, input logic ok,
                      input logic a_n, input logic [1:0] a, input string tag);
    int w;
    @(negedge clk);
    strobe_p_n = p_n; strobe_c_n = c_n; accept = ok; adv_n = a_n; addr_lo = a;
    w = 0;
    if (ok && (!p_n || !c_n)) begin
      m_start = a; m_beat = 2'd0;
    end else if (!a_n) begin
      w = (m_beat == 2'd3) ? 1 : 0;
      m_beat = m_beat + 2'd1;
    end
    q_addr.push_back(expect_addr());
    q_wrap.push_back(w);
    q_tag.push_back(tag);
  endtask

  task automatic drain();
    while (q_addr.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare a quarter period after every rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_addr.size() != 0) begin
        check(q_tag.pop_front(), int'(burst_addr), q_addr.pop_front(),
              int'(wrap_pulse), q_wrap.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe_p_n = 1'b1; strobe_c_n = 1'b1; accept = 1'b0;
    adv_n = 1'b1; addr_lo = 2'd0; order_sel = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 in reset", int'(burst_addr), 0, int'(wrap_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    check("R1 R10 after release", int'(burst_addr), 0, int'(wrap_pulse), 0);

    // Linear order
    step(1'b0, 1'b1, 1'b1, 1'b1, 2'd2, "R2 load processor strobe");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R5 linear beat1");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R5 linear beat2");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R5 linear beat3");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R8 linear wrap");
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, "R8 R9 wrap clears, hold");
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, "R3 load controller strobe");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R5 linear from 1");
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, "R4 strobes not accepted");
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'd3, "R9 accept alone no load");
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'd3, "R7 load beats advance");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R7 beat restarted");
    step(1'b0, 1'b0, 1'b1, 1'b1, 2'd0, "R3 both strobes");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R5 R8 linear from 0");
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, "R9 hold");
    drain();

    // Interleaved order
    @(negedge clk);
    order_sel = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b1, 2'd1, "R2 load interleaved");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R6 interleaved beat1");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R6 interleaved beat2");
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, "R9 hold mid burst");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R6 interleaved beat3");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R8 interleaved wrap");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R8 wrap single cycle");
    step(1'b1, 1'b0, 1'b1, 1'b1, 2'd3, "R3 load 3 interleaved");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R6 from 3");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'd2, "R7 interleaved load priority");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R6 R8 from 2");
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, "R4 ignored interleaved");
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, "R9 idle");
    drain();

    // Reset mid burst
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, "R6 before reset");
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R10 async clear", int'(burst_addr), 0, int'(wrap_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    adv_n = 1'b0;
    @(posedge clk);
    #5;
    check("R10 still held first edge", int'(burst_addr), 0, int'(wrap_pulse), 0);
    adv_n = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check("R1 idle after release", int'(burst_addr), 0, int'(wrap_pulse), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule